// File: doc/BRIEF.md
# Phase-Shifted Ten-Carrier PWM Gate Generator

This block drives the gates of one phase of an eleven-level inverter built from five full-bridge cells whose outputs are wired in series. One phase counter runs a digital triangle, and ten copies of that triangle are taken from it at evenly spaced delays of one tenth of a period each, which is 36 degrees apart. Each copy is compared with a signed reference sample. The comparison results drive the two legs of each cell. The cell outputs (each +1, 0 or -1 times the cell voltage) add up to a staircase with eleven possible levels.

The reference is captured only at the peak of carrier 0, so it stays fixed for each carrier period. A one-cycle sync pulse marks every valley of carrier 0, so that an upstream sine source can deliver the next sample in step with the carriers. The carrier spacing is an input in clocks. The full triangle period is ten times that spacing, and the triangle peak value is five times that spacing.

Top module: `psc_pwm_top`

## Requirements
- R1: While `rst_n` is low or `en_i` is low at a clock edge, every gate bit and `sync_o` are 0 after that edge, and the phase returns to 0.
- R2: With the spacing S = `step_i`, the phase counter advances by one each enabled clock and wraps to 0 after reaching 10*S-1, so the carrier period is 10*S clocks.
- R3: Carrier k (k = 0..9) is carrier 0 delayed by k*S clocks. Carrier 0 at phase p is 2*t-5S, where t = p for p <= 5S and t = 10S-p otherwise.
- R4: For cell c (c = 0..4), the left upper gate is 1 when the held reference is greater than carrier c. The right upper gate is 1 when the negated held reference is greater than carrier c+5. Outputs are registered one clock after the phase they use.
- R5: While enabled, each lower gate is the complement of the upper gate of the same leg, and the two gates of a leg are never 1 together.
- R6: The reference input is loaded into the held reference only at the edge where the phase equals 5S (carrier-0 peak). Changes at any other time have no effect until that edge. The held reference is 0 after reset or disable.
- R7: A held reference greater than 5S puts every cell at +1. A held reference below -5S puts every cell at -1.
- R8: With a held reference of 0, the sum of all cell levels over any 10*S consecutive enabled cycles is 0.
- R9: The summed level of the five cells always lies in -5..+5. Cell c level is +1 when bits 4c (left upper) and 4c+3 (right lower) are set, -1 when bits 4c+1 (left lower) and 4c+2 (right upper) are set, and 0 otherwise.
- R10: `sync_o` is a one-cycle pulse, registered one clock after the phase is 0, and appears exactly once per carrier period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Run enable; low forces gates off and phase to 0 |
| step_i | input | STEP_W | Carrier spacing S in clocks; the period is 10*S |
| ref_i | input | REF_W | Signed reference sample; the full scale is ±5S |
| gate_o | output | 4*NCELL | Per cell c: bit 4c left upper, 4c+1 left lower, 4c+2 right upper, 4c+3 right lower |
| sync_o | output | 1 | One-cycle pulse at each carrier-0 valley |

## Verification
A zero reference shows whether the left and right legs of each cell cancel over a period and whether the carrier shapes are symmetric. Above-full-scale references of both signs show whether each leg compares against the correct carrier and sign. A reference that changes between peaks shows whether the sample is held off the peak. A reference that changes on every clock, run with an odd and an even spacing, is tracked cycle by cycle against a behavioural model. This exposes errors in carrier offsets, fold point, wrap value or output registration.

// File: rtl/psc_pkg.sv
// Shared constants for the phase-shifted carrier PWM generator.
// Assumes a gate bundle of four bits per cell in the order given by gate_idx_e.
package psc_pkg;
    typedef enum int {
        G_LU = 0,  // left leg, upper switch
        G_LL = 1,  // left leg, lower switch
        G_RU = 2,  // right leg, upper switch
        G_RL = 3   // right leg, lower switch
    } gate_idx_e;

    localparam int GATES_PER_CELL = 4;
endpackage

// File: rtl/psc_phase_ctr.sv
// Phase counter, reference hold register and valley sync pulse.
// Assumes step_i >= 1 and that step_i is held constant while enabled.
module psc_phase_ctr #(
    parameter int NCELL  = 5,
    parameter int STEP_W = 8,
    parameter int REF_W  = 16,
    parameter int PH_W   = STEP_W + 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  logic [STEP_W-1:0]       step_i,
    input  logic signed [REF_W-1:0] ref_i,
    output logic [PH_W-1:0]         ph_o,
    output logic signed [REF_W-1:0] ref_o,
    output logic                    sync_o
);
    localparam int NCAR = 2 * NCELL;

    logic [PH_W-1:0]         ph_q;
    logic signed [REF_W-1:0] ref_q;
    logic                    sync_q;
    logic [PH_W-1:0]         per_w;
    logic [PH_W-1:0]         half_w;

    // Period and peak phase, both derived from the spacing.
    always_comb begin
        per_w  = PH_W'(NCAR) * PH_W'(step_i);
        half_w = PH_W'(NCELL) * PH_W'(step_i);
    end

    // Advance the phase, hold the reference from peak to peak, and flag the valley.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            ph_q   <= '0;
            ref_q  <= '0;
            sync_q <= 1'b0;
        end else begin
            sync_q <= (ph_q == '0);
            if (ph_q >= per_w - 1'b1) ph_q <= '0;
            else                      ph_q <= ph_q + 1'b1;
            if (ph_q == half_w) ref_q <= ref_i;
        end
    end

    assign ph_o   = ph_q;
    assign ref_o  = ref_q;
    assign sync_o = sync_q;

    // R2: the phase wraps to zero at the end of the period.
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && ph_q >= per_w - 1'b1) |=> (ph_q == '0));

    // R2: the phase steps by one inside the period.
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && ph_q < per_w - 1'b1) |=> (ph_q == $past(ph_q) + 1'b1));

    // R6: the held reference changes only at the peak phase.
    a_r6_ref_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && ph_q != half_w) |=> (ref_q == $past(ref_q)));

    // R10: a sync pulse follows a zero phase.
    a_r10_sync_valley: assert property (@(posedge clk) disable iff (!rst_n)
        sync_q |-> ($past(ph_q) == '0));
endmodule

// File: rtl/psc_carrier_tap.sv
// One bipolar triangular carrier, delayed by IDX spacings from carrier 0.
// Assumes ph_i < 10*step_i; output range is -5S..+5S.
module psc_carrier_tap #(
    parameter int IDX    = 0,
    parameter int NCELL  = 5,
    parameter int STEP_W = 8,
    parameter int PH_W   = STEP_W + 5,
    parameter int CW     = 18
) (
    input  logic [PH_W-1:0]      ph_i,
    input  logic [STEP_W-1:0]    step_i,
    output logic signed [CW-1:0] car_o
);
    localparam int NCAR = 2 * NCELL;

    logic [PH_W-1:0]      per_w;
    logic [PH_W-1:0]      half_w;
    logic [PH_W-1:0]      off_w;
    logic [PH_W-1:0]      ph_k;
    logic [PH_W-1:0]      tri_w;
    logic signed [CW-1:0] tri_s;

    // Delayed phase modulo the period, folded into a triangle, then centred on zero.
    always_comb begin
        per_w  = PH_W'(NCAR) * PH_W'(step_i);
        half_w = PH_W'(NCELL) * PH_W'(step_i);
        off_w  = PH_W'(IDX) * PH_W'(step_i);
        ph_k   = (ph_i >= off_w) ? (ph_i - off_w) : (ph_i + per_w - off_w);
        tri_w  = (ph_k <= half_w) ? ph_k : (per_w - ph_k);
        tri_s  = $signed(CW'(tri_w));
        car_o  = (tri_s <<< 1) - $signed(CW'(half_w));
    end
endmodule

// File: rtl/psc_leg_cmp.sv
// One H-bridge leg: registered compare of reference against carrier.
// The upper switch follows (ref > carrier), the lower is its complement;
// both are off while reset or disabled.
module psc_leg_cmp #(
    parameter int CW = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic signed [CW-1:0] ref_i,
    input  logic signed [CW-1:0] car_i,
    output logic                 up_o,
    output logic                 lo_o
);
    logic up_q;
    logic lo_q;
    logic hit;

    // Comparator result for this leg.
    always_comb hit = (ref_i > car_i);

    // Register complementary gates, forcing both off when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            up_q <= 1'b0;
            lo_q <= 1'b0;
        end else begin
            up_q <= hit;
            lo_q <= ~hit;
        end
    end

    assign up_o = up_q;
    assign lo_o = lo_q;

    // R5: the two switches of a leg are never on together.
    a_r5_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_q && lo_q));

    // R5: while running, exactly one switch of the leg is on.
    a_r5_complement: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_i) && $past(rst_n)) |-> (up_q != lo_q));

    // R1: a disabled cycle leaves both switches off.
    a_r1_off: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> (!up_q && !lo_q));
endmodule

// File: rtl/psc_pwm_top.sv
// Phase-shifted ten-carrier PWM for a five-cell cascaded full-bridge phase.
// Cell c: left leg vs carrier c, right leg vs carrier c+NCELL with negated reference.
// Assumes step_i >= 1 and constant while enabled; reference full scale is ±NCELL*step_i.
module psc_pwm_top #(
    parameter int NCELL  = 5,
    parameter int STEP_W = 8,
    parameter int REF_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  logic [STEP_W-1:0]       step_i,
    input  logic signed [REF_W-1:0] ref_i,
    output logic [4*NCELL-1:0]      gate_o,
    output logic                    sync_o
);
    import psc_pkg::*;

    localparam int NCAR = 2 * NCELL;
    localparam int PH_W = STEP_W + $clog2(NCAR) + 1;
    localparam int CW   = ((REF_W > PH_W + 2) ? REF_W : PH_W + 2) + 1;

    logic [PH_W-1:0]         ph;
    logic signed [REF_W-1:0] ref_hold;
    logic signed [CW-1:0]    ref_pos;
    logic signed [CW-1:0]    ref_neg;
    logic signed [CW-1:0]    car [NCAR];

    psc_phase_ctr #(
        .NCELL(NCELL), .STEP_W(STEP_W), .REF_W(REF_W), .PH_W(PH_W)
    ) u_ctr (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .step_i(step_i),
        .ref_i(ref_i), .ph_o(ph), .ref_o(ref_hold), .sync_o(sync_o)
    );

    // Sign-extend the held reference and form its negation for the right legs.
    always_comb begin
        ref_pos = CW'(ref_hold);
        ref_neg = -ref_pos;
    end

    for (genvar k = 0; k < NCAR; k++) begin : g_car
        psc_carrier_tap #(
            .IDX(k), .NCELL(NCELL), .STEP_W(STEP_W), .PH_W(PH_W), .CW(CW)
        ) u_tap (
            .ph_i(ph), .step_i(step_i), .car_o(car[k])
        );
    end

    for (genvar c = 0; c < NCELL; c++) begin : g_cell
        psc_leg_cmp #(.CW(CW)) u_left (
            .clk(clk), .rst_n(rst_n), .en_i(en_i),
            .ref_i(ref_pos), .car_i(car[c]),
            .up_o(gate_o[GATES_PER_CELL*c + G_LU]),
            .lo_o(gate_o[GATES_PER_CELL*c + G_LL])
        );
        psc_leg_cmp #(.CW(CW)) u_right (
            .clk(clk), .rst_n(rst_n), .en_i(en_i),
            .ref_i(ref_neg), .car_i(car[c + NCELL]),
            .up_o(gate_o[GATES_PER_CELL*c + G_RU]),
            .lo_o(gate_o[GATES_PER_CELL*c + G_RL])
        );
    end

    // R1: a reset or disabled cycle clears every output.
    a_r1_idle: assert property (@(posedge clk)
        (!$past(rst_n) || !$past(en_i)) |-> (gate_o == '0 && !sync_o));
endmodule

// File: tb/psc_pwm_top_tb.sv
// Bench for psc_pwm_top: behavioural per-cycle model plus scenario checks.
module psc_pwm_top_tb_top;
    localparam int NCELL = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic [7:0]        step = 8'd3;
    logic signed [15:0] refv = '0;
    logic [19:0]       gate;
    logic              sync;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Model state and expectation.
    int m_ph = 0;
    int m_ref = 0;
    logic [19:0] exp_gate = '0;
    logic        exp_sync = 1'b0;
    bit          model_live = 0;

    always #2.5 clk = ~clk;

    psc_pwm_top dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en), .step_i(step),
        .ref_i(refv), .gate_o(gate), .sync_o(sync)
    );

    function automatic int car_val(int ph, int k, int s);
        int p, t, per, h;
        per = 10 * s;
        h   = 5 * s;
        p   = (ph - k * s + 2 * per) % per;
        t   = (p <= h) ? p : per - p;
        return 2 * t - h;
    endfunction

    function automatic int cell_lvl(logic [19:0] g, int c);
        if (g[4*c] && g[4*c+3]) return 1;
        if (g[4*c+1] && g[4*c+2]) return -1;
        return 0;
    endfunction

    function automatic int sum_lvl(logic [19:0] g);
        int s = 0;
        for (int c = 0; c < NCELL; c++) s += cell_lvl(g, c);
        return s;
    endfunction

    // Behavioural model: expectation for the edge, then state update.
    always @(posedge clk) begin
        model_live = 1;
        if (!rst_n || !en) begin
            m_ph = 0; m_ref = 0; exp_gate = '0; exp_sync = 1'b0;
        end else begin
            int s, a, b;
            s = int'(step);
            exp_sync = (m_ph == 0);
            for (int c = 0; c < NCELL; c++) begin
                a = (m_ref > car_val(m_ph, c, s)) ? 1 : 0;
                b = (-m_ref > car_val(m_ph, c + 5, s)) ? 1 : 0;
                exp_gate[4*c]   = a[0];
                exp_gate[4*c+1] = ~a[0];
                exp_gate[4*c+2] = b[0];
                exp_gate[4*c+3] = ~b[0];
            end
            if (m_ph == 5 * s) m_ref = int'(refv);
            m_ph = (m_ph >= 10 * s - 1) ? 0 : m_ph + 1;
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (model_live && !done) begin
            checks++;
            if (gate !== exp_gate || sync !== exp_sync) begin
                errors++;
                $display("FAIL R3/R4/R10 gate act=%h exp=%h sync act=%b exp=%b",
                         gate, exp_gate, sync, exp_sync);
            end
            checks++;
            for (int c = 0; c < NCELL; c++) begin
                if ((gate[4*c] && gate[4*c+1]) || (gate[4*c+2] && gate[4*c+3])) begin
                    errors++;
                    $display("FAIL R5 cell %0d act=%b exp=no shoot-through", c, gate[4*c +: 4]);
                end
            end
            checks++;
            if (sum_lvl(gate) > 5 || sum_lvl(gate) < -5) begin
                errors++;
                $display("FAIL R9 level act=%0d exp=-5..5", sum_lvl(gate));
            end
        end
    end

    task automatic check(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        int sum, nsync;
        cycles(3);
        check("R1 reset gates", int'(gate), 0);
        check("R1 reset sync", int'(sync), 0);

        // Zero reference, S=3: period 30.
        rst_n = 1'b1; step = 8'd3; refv = '0; en = 1'b1;
        sum = 0; nsync = 0;
        for (int i = 0; i < 60; i++) begin
            cycles(1);
            if (i < 30) sum += sum_lvl(gate);
            nsync += int'(sync);
        end
        check("R8 zero-reference period sum", sum, 0);
        check("R10 R2 sync count in two periods", nsync, 2);

        // Disable clears outputs.
        en = 1'b0;
        cycles(2);
        check("R1 disabled gates", int'(gate), 0);

        // Full-scale positive reference, S=4 (peak 20).
        step = 8'd4; refv = 16'sd21; en = 1'b1;
        cycles(85);
        for (int c = 0; c < NCELL; c++) check("R7 positive cell level", cell_lvl(gate, c), 1);

        // Change the input right after a valley: held value must persist until the peak.
        while (!sync) cycles(1);
        refv = -16'sd21;
        cycles(17);
        check("R6 level before peak", sum_lvl(gate), 5);
        cycles(40);
        check("R7 negative full-scale level", sum_lvl(gate), -5);

        // Reference changing on every clock, even spacing S=6.
        en = 1'b0; cycles(1);
        step = 8'd6; en = 1'b1;
        for (int i = 0; i < 600; i++) begin
            refv = 16'(((i * 7) % 61) - 30);
            cycles(1);
        end
        // Odd spacing S=5 with a signed sweep.
        en = 1'b0; cycles(1);
        step = 8'd5; en = 1'b1;
        for (int i = 0; i < 500; i++) begin
            refv = 16'(((i * 13) % 57) - 28);
            cycles(1);
        end
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog act=timeout exp=finish");
        finish_run();
    end
endmodule